// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt source a serial port currently presents to the host and drives the request line. Each cycle it looks at the receive data-ready flag, a transmit-empty pending flag, a modem-change pending flag and the break indicator. Each source is gated by its own enable bit. The block produces an 8-bit identification code from these inputs, using a fixed priority order.

The block owns two pieces of hidden state. The first is the transmit-pending flag, together with the holding-empty and transmitter-empty status bits that qualify it. The second is the modem-change flag. Both are updated from single-cycle strobes sent by the register file and the modem status logic: enable-register write, transmit write, transmit completion, identification read and modem event. The code is combinational and follows its inputs within the same cycle. The request line is registered, so it carries no glitches.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the code is 0x01, `irq` is 0, `thr_empty` is 1, `tx_empty` is 1, and neither pending flag is set.
- R2: When `rx_ready` is 1 and `int_en[0]` is 1, the code is 0x04, whatever else is pending.
- R3: Otherwise, when the transmit-pending flag is set and `int_en[1]` is 1, the code is 0x02.
- R4: Otherwise, when the modem-change flag is set and `int_en[2]` is 1, the code is 0x06.
- R5: Otherwise, when `brk_ind` is 1, the code is 0x00. In all other cases it is 0x01, and bits 7..3 are always 0.
- R6: `irq` equals (code != 0x01) as the code stood one clock earlier.
- R7: A strobe on `iir_rd` clears the transmit-pending flag only when the code shown in that cycle has low 3 bits equal to 0x02. A read that returns any other code leaves the flag set.
- R8: A strobe on `iir_rd` clears the modem-change flag, whatever code it returns.
- R9: A strobe on `en_wr` sets the transmit-pending flag only while `thr_empty` is 1.
- R10: A strobe on `tx_wr` clears the transmit-pending flag, `thr_empty` and `tx_empty`. A strobe on `tx_done` without `tx_wr` sets all three.
- R11: A source whose enable bit is 0 has no effect on the code, but its pending flag is kept. Raising the enable bit later shows that source at once.
- R12: When `modem_evt` and `iir_rd` strobe in the same cycle, the modem-change flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_en | input | 3 | Enable bits: [0] receive data, [1] transmit empty, [2] modem change |
| rx_ready | input | 1 | Receive data-ready flag |
| brk_ind | input | 1 | Break indicator flag |
| en_wr | input | 1 | Strobe: enable register written |
| tx_wr | input | 1 | Strobe: byte written to holding register |
| tx_done | input | 1 | Strobe: transmission of that byte complete |
| iir_rd | input | 1 | Strobe: identification register read |
| modem_evt | input | 1 | Strobe: modem status lines changed |
| iir_code | output | 8 | Interrupt identification code |
| irq | output | 1 | Registered interrupt request |
| thr_empty | output | 1 | Holding-register-empty status |
| tx_empty | output | 1 | Transmitter-empty status |

## Verification
A change on `rx_ready`, `brk_ind` or `int_en` reaches `iir_code` in the same cycle. The bench therefore checks the code one time step after it drives a level input, before any clock edge passes. A strobe updates the flags at the edge that samples it, so the code and status outputs are checked at the falling edge that follows that rising edge. `irq` is due one further rising edge later, and it is checked only after that extra edge. All stimulus is driven on falling edges, so that every sample falls half a period away from the edge that produced it.

// File: rtl/uart_int_pkg.sv
// Shared constants for the interrupt identification logic.
// Assumes an 8-bit identification register whose low three bits carry the code.
package uart_int_pkg;
    localparam int CODE_W = 8;
    localparam int EN_W   = 3;
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_MS  = 2;

    localparam logic [CODE_W-1:0] CODE_RX    = 8'h04;
    localparam logic [CODE_W-1:0] CODE_TX    = 8'h02;
    localparam logic [CODE_W-1:0] CODE_MS    = 8'h06;
    localparam logic [CODE_W-1:0] CODE_BRK   = 8'h00;
    localparam logic [CODE_W-1:0] CODE_NONE  = 8'h01;
    localparam logic [2:0]        ID_TX_LOW  = 3'b010;
endpackage

// File: rtl/uart_tx_pend.sv
// Tracks the transmit-pending flag and the holding/transmitter empty bits.
// Assumes one-cycle strobes. Order within a cycle: transmit write, then
// completion, then the clear from an identification read, then the set from an enable write.
module uart_tx_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_wr,
    input  logic tx_done,
    input  logic rd_clr,
    input  logic en_wr,
    output logic pend,
    output logic thre,
    output logic temt
);
    // Update the pending flag and empty status from the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            thre <= 1'b1;
            temt <= 1'b1;
        end else if (tx_wr) begin
            pend <= 1'b0;
            thre <= 1'b0;
            temt <= 1'b0;
        end else if (tx_done) begin
            pend <= 1'b1;
            thre <= 1'b1;
            temt <= 1'b1;
        end else if (rd_clr) begin
            pend <= 1'b0;
        end else if (en_wr && thre) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_modem_flag.sv
// Holds the modem-change pending flag.
// A new event in the same cycle as a read wins, so that no change is lost.
module uart_modem_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    output logic chg
);
    // Set on an event, clear on any identification read.
    always_ff @(posedge clk) begin
        if (!rst_n)   chg <= 1'b0;
        else if (evt) chg <= 1'b1;
        else if (rd)  chg <= 1'b0;
    end
endmodule

// File: rtl/uart_int_prio.sv
// Combinational fixed-priority encoder: receive data, then transmit empty,
// then modem change, then break-only, else no interrupt.
module uart_int_prio
    import uart_int_pkg::*;
(
    input  logic [EN_W-1:0]   en,
    input  logic              rx_ready,
    input  logic              tx_pend,
    input  logic              ms_chg,
    input  logic              brk,
    output logic [CODE_W-1:0] code
);
    // Pick the highest enabled source.
    always_comb begin
        if (rx_ready && en[EN_RX])     code = CODE_RX;
        else if (tx_pend && en[EN_TX]) code = CODE_TX;
        else if (ms_chg && en[EN_MS])  code = CODE_MS;
        else if (brk)                  code = CODE_BRK;
        else                           code = CODE_NONE;
    end
endmodule

// File: rtl/uart_int_ident.sv
// Interrupt identification top. The code is combinational and follows its
// inputs in the same cycle. The request line is registered one cycle behind it.
// Assumes all strobes last exactly one clock.
module uart_int_ident
    import uart_int_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EN_W-1:0]   int_en,
    input  logic              rx_ready,
    input  logic              brk_ind,
    input  logic              en_wr,
    input  logic              tx_wr,
    input  logic              tx_done,
    input  logic              iir_rd,
    input  logic              modem_evt,
    output logic [CODE_W-1:0] iir_code,
    output logic              irq,
    output logic              thr_empty,
    output logic              tx_empty
);
    logic tx_pend;
    logic ms_chg;
    logic rd_tx_clr;

    // A read clears the transmit flag only if it reports that source.
    assign rd_tx_clr = iir_rd && (iir_code[2:0] == ID_TX_LOW);

    uart_tx_pend u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_wr  (tx_wr),
        .tx_done(tx_done),
        .rd_clr (rd_tx_clr),
        .en_wr  (en_wr),
        .pend   (tx_pend),
        .thre   (thr_empty),
        .temt   (tx_empty)
    );

    uart_modem_flag u_ms (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (modem_evt),
        .rd   (iir_rd),
        .chg  (ms_chg)
    );

    uart_int_prio u_prio (
        .en      (int_en),
        .rx_ready(rx_ready),
        .tx_pend (tx_pend),
        .ms_chg  (ms_chg),
        .brk     (brk_ind),
        .code    (iir_code)
    );

    // Register the request so that it carries no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (iir_code != CODE_NONE);
    end
endmodule

// File: rtl/uart_int_ident_chk.sv
// Property checker for uart_int_ident, attached by bind.
module uart_int_ident_chk
    import uart_int_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [EN_W-1:0]   int_en,
    input logic              rx_ready,
    input logic              tx_wr,
    input logic              tx_done,
    input logic              iir_rd,
    input logic              modem_evt,
    input logic [CODE_W-1:0] iir_code,
    input logic              irq,
    input logic              thr_empty,
    input logic              tx_empty
);
    assert_rx_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && int_en[EN_RX]) |-> (iir_code == CODE_RX));

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_code == CODE_RX) || (iir_code == CODE_TX) || (iir_code == CODE_MS) ||
        (iir_code == CODE_BRK) || (iir_code == CODE_NONE));

    assert_irq_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ($past(iir_code) != CODE_NONE)));

    assert_read_clears_ms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !modem_evt) |=> (iir_code != CODE_MS));

    assert_txwr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (!thr_empty && !tx_empty && (iir_code != CODE_TX)));

    assert_txdone_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_wr) |=> (thr_empty && tx_empty));
endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_en   (int_en),
    .rx_ready (rx_ready),
    .tx_wr    (tx_wr),
    .tx_done  (tx_done),
    .iir_rd   (iir_rd),
    .modem_evt(modem_evt),
    .iir_code (iir_code),
    .irq      (irq),
    .thr_empty(thr_empty),
    .tx_empty (tx_empty)
);

// File: tb/tb_uart_int_ident.sv
module tb_uart_int_ident;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] int_en = '0;
    logic       rx_ready = 1'b0, brk_ind = 1'b0;
    logic       en_wr = 1'b0, tx_wr = 1'b0, tx_done = 1'b0, iir_rd = 1'b0, modem_evt = 1'b0;
    logic [7:0] iir_code;
    logic       irq, thr_empty, tx_empty;
    int         n_chk = 0, n_bad = 0;
    bit         ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_int_ident dut (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .rx_ready(rx_ready), .brk_ind(brk_ind),
        .en_wr(en_wr), .tx_wr(tx_wr), .tx_done(tx_done), .iir_rd(iir_rd), .modem_evt(modem_evt),
        .iir_code(iir_code), .irq(irq), .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // Advance one rising edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Strobe selection: 0 en_wr, 1 tx_wr, 2 tx_done, 3 iir_rd, 4 modem_evt.
    task automatic pulse(input logic [4:0] sel);
        {modem_evt, iir_rd, tx_done, tx_wr, en_wr} = sel;
        step();
        {modem_evt, iir_rd, tx_done, tx_wr, en_wr} = '0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 code", iir_code, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 thr_empty", {7'd0, thr_empty}, 8'h01);
        check("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
    endtask

    task automatic t_enable_write();
        int_en = 3'b010;
        pulse(5'b00001);
        check("R9 set on enable write", iir_code, 8'h02);
        check("R3 tx code", iir_code, 8'h02);
        step();
        check("R6 irq high", {7'd0, irq}, 8'h01);
        pulse(5'b01000);
        check("R7 read of tx code clears", iir_code, 8'h01);
        step();
        check("R6 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_tx_cycle();
        pulse(5'b00010);
        check("R10 thr_empty cleared", {7'd0, thr_empty}, 8'h00);
        check("R10 tx_empty cleared", {7'd0, tx_empty}, 8'h00);
        pulse(5'b00001);
        check("R9 no set while busy", iir_code, 8'h01);
        pulse(5'b00100);
        check("R10 done sets pend", iir_code, 8'h02);
        check("R10 thr_empty set", {7'd0, thr_empty}, 8'h01);
        check("R10 tx_empty set", {7'd0, tx_empty}, 8'h01);
        pulse(5'b01000);
        check("R7 cleared again", iir_code, 8'h01);
    endtask

    task automatic t_modem();
        int_en = 3'b000;
        pulse(5'b10000);
        check("R11 disabled modem ignored", iir_code, 8'h01);
        int_en = 3'b100;
        #1;
        check("R11 kept flag shows", iir_code, 8'h06);
        check("R4 modem code", iir_code, 8'h06);
        pulse(5'b01000);
        check("R8 read clears modem", iir_code, 8'h01);
    endtask

    task automatic t_priority();
        int_en = 3'b111;
        pulse(5'b00001);
        pulse(5'b10000);
        check("R3 tx above modem", iir_code, 8'h02);
        rx_ready = 1'b1;
        #1;
        check("R2 rx highest", iir_code, 8'h04);
        pulse(5'b01000);
        rx_ready = 1'b0;
        #1;
        check("R7 tx kept after rx read", iir_code, 8'h02);
        pulse(5'b01000);
        check("R8 modem cleared by rx read", iir_code, 8'h01);
    endtask

    task automatic t_break();
        int_en = 3'b000;
        brk_ind = 1'b1;
        #1;
        check("R5 break code", iir_code, 8'h00);
        step();
        check("R6 irq on break", {7'd0, irq}, 8'h01);
        rx_ready = 1'b1;
        #1;
        check("R11 rx disabled", iir_code, 8'h00);
        int_en = 3'b001;
        #1;
        check("R2 rx over break", iir_code, 8'h04);
        rx_ready = 1'b0;
        brk_ind = 1'b0;
        #1;
        check("R5 none", iir_code, 8'h01);
    endtask

    task automatic t_simul();
        int_en = 3'b100;
        pulse(5'b11000);
        check("R12 event beats read", iir_code, 8'h06);
        pulse(5'b01000);
        check("R8 cleared", iir_code, 8'h01);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable_write();
        t_tx_cycle();
        t_modem();
        t_priority();
        t_break();
        t_simul();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule